// File: doc/BRIEF.md
# Serial RTC Register File with Read Snapshot

This block holds the byte-addressed register space of a serial-bus real-time clock with battery-backed RAM. A bus-slave front end, outside this block, turns bit-level traffic into four one-cycle events: a write-direction START, a received data byte, a read-direction START and a request for the next byte to send. The block keeps an auto-incrementing address pointer and answers each request from its storage.

The first seven bytes are timekeeping fields. The counter that runs the clock lies outside this block and presents its current values on a packed input. Reads of these addresses never see the live counter directly. A read-direction START, and every wrap of the pointer back to zero, copies the live fields into shadow bytes, so that a multi-byte read returns one consistent instant. Writes to these addresses are not stored here. They are passed to the counter as a one-cycle load strobe with the field index and the byte.

Address 7 is a control byte with masked bits and a sticky oscillator-stop flag. An external set input can raise that flag. The remaining addresses are plain RAM.

Top module: `rtc_regfile`

## Requirements
- R1: The address pointer is 6 bits wide (64 addresses) and wraps from 63 to 0.
- R2: The first data byte after a write-direction START loads the pointer from its low 6 bits, ignoring bits 7:6. That byte is not stored and raises no load strobe.
- R3: A read-direction START copies the live time bytes 0 to 6 into the shadow bytes. Reads of addresses 0 to 6 return the shadow copy even after the live input changes.
- R4: Every byte read and every non-address byte written advances the pointer by one. An advance that wraps to 0 copies the live time into the shadow bytes again.
- R5: A data byte written while the pointer is 0 to 6 raises `load_valid` in that same cycle, with `load_field` equal to the pointer and `load_byte` equal to the byte. The shadow byte at that address keeps its value.
- R6: Addresses 8 to 63 store written bytes and read them back unchanged.
- R7: A write to the control byte at address 7 always stores bits 6, 3 and 2 as 0, which is an AND mask of 0xB3.
- R8: Control bit 5 (oscillator-stop flag) is cleared by writing 0 to it. Writing 1 leaves its present value.
- R9: After reset every byte reads 0, the pointer is 0 and no address byte is pending.
- R10: A high `osc_stop_set` sets control bit 5 at the next edge. It takes priority over a write in the same cycle.
- R11: `rd_byte` shows the byte at the pointer in the same cycle as `ev_rd_req`, and the pointer advances on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_wr | input | 1 | Write-direction START seen by the front end |
| ev_start_rd | input | 1 | Read-direction START seen by the front end |
| ev_wr_valid | input | 1 | A byte was received |
| ev_wr_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | Front end takes the next byte to send |
| rd_byte | output | 8 | Byte at the current pointer |
| live_time | input | 56 | Live counter fields; field i at bits 8i+7:8i |
| osc_stop_set | input | 1 | Raises the oscillator-stop flag |
| load_valid | output | 1 | One-cycle load strobe to the counter |
| load_field | output | 3 | Time field index of the load |
| load_byte | output | 8 | Value to load |

## Verification
The snapshot is tested by changing `live_time` between the capture and the reads. This shows whether a byte comes from the shadow or from the live input, and whether it was taken at the START or at the pointer wrap. RAM bytes are written with an address byte whose top bits are set, which exposes any use of more than 6 pointer bits. The control byte is written with all-ones and all-zeros patterns, both before and after the external flag set. This separates the fixed mask from the sticky clear-only flag and from the set priority. Time-field writes are checked on the strobe outputs and by reading the shadow back. This shows that such writes reach the counter and leave the register space unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_ADDR_W    = 6;
    localparam int RTC_NUM_TIME  = 7;
    localparam int RTC_CTRL_ADDR = 7;
    localparam logic [7:0] RTC_CTRL_KEEP = 8'hB3;
    localparam int RTC_OSF_BIT   = 5;
endpackage

// File: rtl/rtc_ptr_step.sv
module rtc_ptr_step #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              wraps
);
    always_comb begin
        ptr_next = ptr + ADDR_W'(1);
        wraps    = (ptr == {ADDR_W{1'b1}});
    end
endmodule

// File: rtl/rtc_ctrl_merge.sv
module rtc_ctrl_merge #(
    parameter logic [7:0] KEEP    = 8'hB3,
    parameter int         OSF_BIT = 5
) (
    input  logic [7:0] cur,
    input  logic [7:0] wdata,
    input  logic       we,
    input  logic       flag_set,
    output logic [7:0] nxt
);
    localparam logic [7:0] OSF_MASK = 8'(1) << OSF_BIT;

    always_comb begin
        nxt = cur;
        if (we) begin
            nxt = (wdata & KEEP & ~OSF_MASK) | (wdata & cur & OSF_MASK);
        end
        if (flag_set) begin
            nxt = nxt | OSF_MASK;
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = RTC_ADDR_W,
    parameter int NUM_TIME  = RTC_NUM_TIME,
    parameter int CTRL_ADDR = RTC_CTRL_ADDR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_start_wr,
    input  logic                  ev_start_rd,
    input  logic                  ev_wr_valid,
    input  logic [7:0]            ev_wr_byte,
    input  logic                  ev_rd_req,
    output logic [7:0]            rd_byte,
    input  logic [NUM_TIME*8-1:0] live_time,
    input  logic                  osc_stop_set,
    output logic                  load_valid,
    output logic [2:0]            load_field,
    output logic [7:0]            load_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [ADDR_W-1:0]     ptr;
        logic                  pend;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] ptr_inc;
    logic              ptr_wraps;
    logic [7:0]        ctrl_nxt;
    logic              data_phase;
    logic              advance;
    logic              capture;
    logic              ctrl_we;

    // observation nets for the bound checker
    logic [ADDR_W-1:0]     ptr_q;
    logic                  pend_q;
    logic [7:0]            ctrl_q;
    logic [NUM_TIME*8-1:0] shadow_q;

    rtc_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .ptr      (st_q.ptr),
        .ptr_next (ptr_inc),
        .wraps    (ptr_wraps)
    );

    rtc_ctrl_merge #(.KEEP(RTC_CTRL_KEEP), .OSF_BIT(RTC_OSF_BIT)) u_ctrl (
        .cur      (st_q.mem[CTRL_ADDR]),
        .wdata    (ev_wr_byte),
        .we       (ctrl_we),
        .flag_set (osc_stop_set),
        .nxt      (ctrl_nxt)
    );

    assign data_phase = ev_wr_valid && !st_q.pend;
    assign advance    = ev_rd_req || data_phase;
    assign capture    = ev_start_rd || (advance && ptr_wraps);
    assign ctrl_we    = data_phase && (st_q.ptr == ADDR_W'(CTRL_ADDR));

    always_comb begin
        st_d = st_q;
        if (ev_start_wr) begin
            st_d.pend = 1'b1;
        end
        if (ev_wr_valid && st_q.pend) begin
            st_d.ptr  = ev_wr_byte[ADDR_W-1:0];
            st_d.pend = 1'b0;
        end else if (advance) begin
            st_d.ptr = ptr_inc;
        end
        if (data_phase && (st_q.ptr >= ADDR_W'(NUM_TIME))
            && (st_q.ptr != ADDR_W'(CTRL_ADDR))) begin
            st_d.mem[st_q.ptr] = ev_wr_byte;
        end
        st_d.mem[CTRL_ADDR] = ctrl_nxt;
        if (capture) begin
            for (int i = 0; i < NUM_TIME; i++) begin
                st_d.mem[i] = live_time[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_byte    = st_q.mem[st_q.ptr];
    assign load_valid = data_phase && (st_q.ptr < ADDR_W'(NUM_TIME));
    assign load_field = st_q.ptr[2:0];
    assign load_byte  = ev_wr_byte;

    assign ptr_q  = st_q.ptr;
    assign pend_q = st_q.pend;
    assign ctrl_q = st_q.mem[CTRL_ADDR];

    generate
        for (genvar g = 0; g < NUM_TIME; g++) begin : g_shadow
            assign shadow_q[g*8 +: 8] = st_q.mem[g];
        end
    endgenerate
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
    parameter int ADDR_W   = 6,
    parameter int NUM_TIME = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ev_start_wr,
    input logic                  ev_start_rd,
    input logic                  ev_wr_valid,
    input logic [7:0]            ev_wr_byte,
    input logic                  ev_rd_req,
    input logic                  osc_stop_set,
    input logic [NUM_TIME*8-1:0] live_time,
    input logic                  load_valid,
    input logic [ADDR_W-1:0]     ptr_q,
    input logic                  pend_q,
    input logic [7:0]            ctrl_q,
    input logic [NUM_TIME*8-1:0] shadow_q
);
    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_req && !ev_wr_valid && !ev_start_wr && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr_valid && pend_q && !ev_start_wr) |=> (ptr_q == $past(ev_wr_byte[ADDR_W-1:0]) && !pend_q));

    // R3
    rd_start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_rd |=> (shadow_q == $past(live_time)));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_req && !ev_wr_valid) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    // R5
    strobe_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !ev_start_rd) |=> $stable(shadow_q));

    // R7
    ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & 8'h4C) == 8'h00);

    // R10
    osf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_set |=> ctrl_q[5]);
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W), .NUM_TIME(NUM_TIME)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start_wr  (ev_start_wr),
    .ev_start_rd  (ev_start_rd),
    .ev_wr_valid  (ev_wr_valid),
    .ev_wr_byte   (ev_wr_byte),
    .ev_rd_req    (ev_rd_req),
    .osc_stop_set (osc_stop_set),
    .live_time    (live_time),
    .load_valid   (load_valid),
    .ptr_q        (ptr_q),
    .pend_q       (pend_q),
    .ctrl_q       (ctrl_q),
    .shadow_q     (shadow_q)
);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_start_wr, ev_start_rd, ev_wr_valid, ev_rd_req, osc_stop_set;
    logic [7:0]  ev_wr_byte;
    logic [55:0] live_time;
    logic [7:0]  rd_byte, load_byte;
    logic        load_valid;
    logic [2:0]  load_field;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtc_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
        .ev_wr_valid(ev_wr_valid), .ev_wr_byte(ev_wr_byte),
        .ev_rd_req(ev_rd_req), .rd_byte(rd_byte),
        .live_time(live_time), .osc_stop_set(osc_stop_set),
        .load_valid(load_valid), .load_field(load_field), .load_byte(load_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] pattern(input logic [7:0] base);
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = base + 8'(i);
        return v;
    endfunction

    task automatic idle();
        ev_start_wr = 0; ev_start_rd = 0; ev_wr_valid = 0; ev_rd_req = 0;
        osc_stop_set = 0; ev_wr_byte = 8'h00;
    endtask

    task automatic start_wr();
        @(negedge clk); idle(); ev_start_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic start_rd();
        @(negedge clk); idle(); ev_start_rd = 1;
        @(negedge clk); idle();
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); idle(); ev_wr_valid = 1; ev_wr_byte = b;
        @(negedge clk); idle();
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); idle(); ev_rd_req = 1;
        #1 b = rd_byte;
        @(negedge clk); idle();
    endtask

    task automatic seek(input logic [7:0] a);
        start_wr(); put(a);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        get(b); check("R9 byte0", b, 8'h00);
        get(b); check("R9 byte1", b, 8'h00);
        seek(8'h07); get(b); check("R9 ctrl", b, 8'h00);
        seek(8'h20); get(b); check("R9 ram", b, 8'h00);
    endtask

    task automatic t_ram();
        logic [7:0] b;
        start_wr(); put(8'hC8); put(8'hA5); put(8'h5A);
        seek(8'h08); start_rd();
        get(b); check("R6 ram 8", b, 8'hA5);
        get(b); check("R2/R6 ram 9", b, 8'h5A);
        get(b); check("R2 addr byte not stored at 10", b, 8'h00);
    endtask

    task automatic t_timing();
        logic [7:0] b;
        seek(8'h30); put(8'h11); put(8'h22);
        seek(8'h30);
        @(negedge clk); idle(); ev_rd_req = 1;
        #1 check("R11 same-cycle data", rd_byte, 8'h11);
        @(posedge clk); #1 check("R11 next-edge advance", rd_byte, 8'h22);
        @(negedge clk); idle();
        get(b); check("R4 read advance", b, 8'h22);
    endtask

    task automatic t_snapshot();
        logic [7:0] b;
        live_time = pattern(8'h40);
        seek(8'h00); start_rd();
        live_time = pattern(8'h90);
        for (int i = 0; i < 7; i++) begin
            get(b); check("R3 shadow", b, 8'h40 + 8'(i));
        end
    endtask

    task automatic t_load();
        logic [7:0] b;
        seek(8'h02);
        @(negedge clk); idle(); ev_wr_valid = 1; ev_wr_byte = 8'h15;
        #1 check("R5 strobe", load_valid, 1'b1);
        check("R5 field", load_field, 3'd2);
        check("R5 byte", load_byte, 8'h15);
        @(negedge clk); idle();
        start_wr();
        @(negedge clk); idle(); ev_wr_valid = 1; ev_wr_byte = 8'h02;
        #1 check("R2 no strobe on address", load_valid, 1'b0);
        @(negedge clk); idle();
        get(b); check("R5 shadow kept", b, 8'h42);
    endtask

    task automatic t_ctrl();
        logic [7:0] b;
        seek(8'h07); put(8'hFF);
        seek(8'h07); get(b); check("R7/R8 mask, flag stays 0", b, 8'h93);
        @(negedge clk); idle(); osc_stop_set = 1;
        @(negedge clk); idle();
        seek(8'h07); get(b); check("R10 set", b, 8'hB3);
        seek(8'h07); put(8'hFF);
        seek(8'h07); get(b); check("R8 write 1 keeps", b, 8'hB3);
        seek(8'h07); put(8'h00);
        seek(8'h07); get(b); check("R8 write 0 clears", b, 8'h00);
        seek(8'h07);
        @(negedge clk); idle(); ev_wr_valid = 1; ev_wr_byte = 8'h00; osc_stop_set = 1;
        @(negedge clk); idle();
        seek(8'h07); get(b); check("R10 priority over write", b, 8'h20);
    endtask

    task automatic t_wrap();
        logic [7:0] b;
        seek(8'h3F);
        live_time = pattern(8'h60);
        put(8'h77);
        live_time = pattern(8'hA0);
        get(b); check("R1/R4 write wrap capture", b, 8'h60);
        seek(8'h3E); start_rd();
        live_time = pattern(8'hC0);
        get(b); check("R6 ram 62", b, 8'h00);
        get(b); check("R6 ram 63", b, 8'h77);
        live_time = pattern(8'hE0);
        get(b); check("R1/R4 read wrap capture", b, 8'hC0);
        get(b); check("R4 after wrap", b, 8'hC1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        live_time = pattern(8'h10);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ram();
        t_timing();
        t_snapshot();
        t_load();
        t_ctrl();
        t_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule